// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt inputs, keeps a request register, an in-service register and a mask register, and resolves the highest-priority unmasked request against a stored lowest-priority level. When a request is eligible it raises a single interrupt output. The processor side then pulses an acknowledge input. The winner moves from request to in-service, and the block returns a vector built from a programmed base and the winning input number.

Software reaches the block through a byte-wide synchronous write port with one address bit. A command byte at address 0 starts initialization or issues an operation command. Writes at address 1 carry the follow-on initialization words and, once initialization is done, the mask. A combinational read port returns the mask, or the request or in-service register as selected by command. A special mask mode lets levels interrupt regardless of what is in service. A special nested mode keeps the cascade input from blocking further requests while it is in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are 0, the interrupt output is 0, the vector is 0, readback selects the request register, special mask mode is off and input 0 has the highest priority.
- R2: A 0-to-1 transition on input i sets request bit i on the next clock edge. An acknowledge that selects input i clears that bit, unless a new rising edge arrives in the same cycle.
- R3: Priority descends from the level just above the stored lowest level. With the lowest level at 7, input 0 is highest and input 7 is lowest.
- R4: The interrupt output is registered and goes high one cycle after an unmasked pending request becomes eligible. In normal mode a set in-service bit blocks its own level and every lower level, and masked requests never raise the output.
- R5: On acknowledge, the eligible winner's in-service bit is set and its request bit is cleared. The vector becomes base*8 plus the input number on the same edge. With no eligible request the vector is base*8+7 and the registers are unchanged.
- R6: Writing 0x20 to address 0 is a non-specific end-of-interrupt. In normal mode it clears the highest-priority set in-service bit.
- R7: A byte at address 0 with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 6 enables a change of special mask mode and bit 5 gives the new value; with bit 6 clear the mode is kept. Bit 1 enables a change of read select and bit 0 picks in-service (1) or request (0). Read address 1 returns the mask.
- R8: In special mask mode the in-service register has no effect on eligibility. Any unmasked pending request raises the output.
- R9: In special mask mode an end-of-interrupt skips in-service bits whose mask bit is set and clears the highest-priority unmasked one. If no bit qualifies, nothing changes.
- R10: A byte at address 0 with bit 4 = 1 starts initialization. It sets the lowest level to 7, clears special mask mode and read select, and drives the unsupported flag to its bit 1 (single mode requested). The next three address-1 writes are taken as the vector base (bits 7:3), a cascade word with no effect, and a mode word whose bit 4 enables special nested mode. Later address-1 writes set the mask.
- R11: In special nested mode a set in-service bit for input 2 does not block any level.
- R12: An acknowledge and an end-of-interrupt in the same cycle both take effect. Both are judged on the registers before the edge, and the bit that is set wins over the bit that is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Interrupt inputs, rising-edge detected |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 1 | Write address: 0 command, 1 data |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read address: 0 request/in-service, 1 mask |
| rdData | output | 8 | Read data |
| intAck | input | 1 | Interrupt acknowledge pulse |
| intOut | output | 1 | Interrupt output |
| ackVector | output | 8 | Vector returned by the last acknowledge |
| initUnsupported | output | 1 | Single mode was requested at initialization |

## Verification
An acknowledge and a non-specific end-of-interrupt can land on the same clock edge: one sets an in-service bit, the other clears one. The bench provokes this by holding a lower level in service while a higher level is pending, then pulsing the acknowledge together with the end-of-interrupt write. It judges the in-service readback and the vector against a behavioural model that resolves both operations from the state before the edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_IRQ    = 8;
  localparam int IDX_W    = $clog2(N_IRQ);
  localparam int BASE_W   = 8 - IDX_W;
  localparam int CASC_PIN = 2;

  typedef struct packed {
    logic initCmd;
    logic maskWr;
    logic eoiCmd;
    logic ackReq;
  } picStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int IDX_BITS  = IDX_W,
  parameter int BASE_BITS = BASE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 intAck,
  output picStrobe_t           strobe,
  output logic                 smmOn,
  output logic                 sfnmOn,
  output logic                 readIsr,
  output logic [BASE_BITS-1:0] vecBase,
  output logic                 unsupported
);
  typedef enum logic [1:0] {STEP_RUN, STEP_BASE, STEP_CASC, STEP_MODE} initStep_t;

  initStep_t step;
  logic isCmd, isInit, isMode, isEoi, dataWr;

  assign isCmd  = wrEn && !wrAddr;
  assign isInit = isCmd && wrData[4];
  assign isMode = isCmd && !wrData[4] && wrData[3];
  assign isEoi  = isCmd && (wrData == 8'h20);
  assign dataWr = wrEn && wrAddr;

  assign strobe.initCmd = isInit;
  assign strobe.maskWr  = dataWr && (step == STEP_RUN);
  assign strobe.eoiCmd  = isEoi;
  assign strobe.ackReq  = intAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step        <= STEP_RUN;
      smmOn       <= 1'b0;
      sfnmOn      <= 1'b0;
      readIsr     <= 1'b0;
      vecBase     <= '0;
      unsupported <= 1'b0;
    end else if (isInit) begin
      step        <= STEP_BASE;
      smmOn       <= 1'b0;
      readIsr     <= 1'b0;
      unsupported <= wrData[1];
    end else if (dataWr) begin
      case (step)
        STEP_BASE: begin vecBase <= wrData[7:IDX_BITS]; step <= STEP_CASC; end
        STEP_CASC: step <= STEP_MODE;
        STEP_MODE: begin sfnmOn <= wrData[4]; step <= STEP_RUN; end
        default:   step <= STEP_RUN;
      endcase
    end else if (isMode) begin
      if (wrData[6]) smmOn   <= wrData[5];
      if (wrData[1]) readIsr <= wrData[0];
    end
  end

  // R10: initialization leaves special mask mode and ISR readback off
  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    isInit |=> (!smmOn && !readIsr));

  // R7: a mode command without the enable bit keeps special mask mode
  assert_smm_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isMode && !wrData[6]) |=> (smmOn == $past(smmOn)));
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM       = N_IRQ,
  parameter int IDX_BITS  = IDX_W,
  parameter int BASE_BITS = BASE_W,
  parameter int CASC_IDX  = CASC_PIN
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM-1:0]       irqIn,
  input  picStrobe_t           strobe,
  input  logic [NUM-1:0]       wrData,
  input  logic                 smmOn,
  input  logic                 sfnmOn,
  input  logic                 readIsr,
  input  logic [BASE_BITS-1:0] vecBase,
  input  logic                 rdAddr,
  output logic                 intOut,
  output logic [7:0]           ackVector,
  output logic [NUM-1:0]       rdData
);
  logic [NUM-1:0]      irr, isr, imr, irqPrev;
  logic [IDX_BITS-1:0] lowPrio, scanPin, winIdx, eoiIdx;
  logic [NUM-1:0]      blockMask, rise, ackSet, eoiClr;
  logic                winValid, stopScan, eoiValid;

  always_comb begin
    blockMask = smmOn ? '0 : isr;
    if (sfnmOn) blockMask[CASC_IDX] = 1'b0;
    winValid = 1'b0;
    winIdx   = '0;
    stopScan = 1'b0;
    eoiValid = 1'b0;
    eoiIdx   = '0;
    scanPin  = '0;
    for (int k = 0; k < NUM; k++) begin
      scanPin = lowPrio + IDX_BITS'(k + 1);
      if (!winValid && !stopScan) begin
        if (blockMask[scanPin]) stopScan = 1'b1;
        else if (irr[scanPin] && !imr[scanPin]) begin
          winValid = 1'b1;
          winIdx   = scanPin;
        end
      end
      if (!eoiValid && isr[scanPin] && !(smmOn && imr[scanPin])) begin
        eoiValid = 1'b1;
        eoiIdx   = scanPin;
      end
    end
  end

  assign rise   = irqIn & ~irqPrev;
  assign ackSet = (strobe.ackReq && winValid) ? (NUM'(1) << winIdx) : '0;
  assign eoiClr = (strobe.eoiCmd && eoiValid) ? (NUM'(1) << eoiIdx) : '0;
  assign rdData = rdAddr ? imr : (readIsr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr       <= '0;
      isr       <= '0;
      imr       <= '0;
      irqPrev   <= '0;
      lowPrio   <= '1;
      intOut    <= 1'b0;
      ackVector <= '0;
    end else begin
      irqPrev <= irqIn;
      irr     <= (irr & ~ackSet) | rise;
      isr     <= (isr & ~eoiClr) | ackSet;
      intOut  <= winValid;
      if (strobe.ackReq) ackVector <= {vecBase, (winValid ? winIdx : {IDX_BITS{1'b1}})};
      if (strobe.maskWr) imr <= wrData;
      if (strobe.initCmd) lowPrio <= '1;
    end
  end

  // R4: the output only rises from an unmasked pending request
  assert_int_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> $past(|(irr & ~imr)));

  // R5: an acknowledged winner enters service
  assert_ack_service_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackReq && winValid) |=> isr[$past(winIdx)]);

  // R6: a lone end-of-interrupt retires exactly one level
  assert_eoi_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiCmd && eoiValid && !strobe.ackReq)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R9: with every in-service level masked, special-mask EOI changes nothing
  assert_smm_skip_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiCmd && smmOn && ((isr & ~imr) == '0) && !strobe.ackReq)
      |=> (isr == $past(isr)));

  // R10: initialization restores the default lowest level
  assert_init_prio_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initCmd |=> (lowPrio == IDX_BITS'(NUM - 1)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdAddr,
  output logic [7:0] rdData,
  input  logic       intAck,
  output logic       intOut,
  output logic [7:0] ackVector,
  output logic       initUnsupported
);
  picStrobe_t        strobe;
  logic              smmOn, sfnmOn, readIsr;
  logic [BASE_W-1:0] vecBase;

  pic_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .intAck(intAck), .strobe(strobe), .smmOn(smmOn), .sfnmOn(sfnmOn),
    .readIsr(readIsr), .vecBase(vecBase), .unsupported(initUnsupported)
  );

  pic_datapath dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe), .wrData(wrData),
    .smmOn(smmOn), .sfnmOn(sfnmOn), .readIsr(readIsr), .vecBase(vecBase),
    .rdAddr(rdAddr), .intOut(intOut), .ackVector(ackVector), .rdData(rdData)
  );
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = 8'h00;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdAddr = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] rdData, ackVector;
  logic       intOut, initUnsupported;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .intAck(intAck),
    .intOut(intOut), .ackVector(ackVector), .initUnsupported(initUnsupported)
  );

  // Behavioural reference model
  bit [7:0] mIrr, mIsr, mImr, mPrev;
  int       mLow, mBase, mStep, mVec;
  bit       mSmm, mSfnm, mRdIsr, mUns, mInt;

  function automatic int mResolve();
    for (int k = 0; k < 8; k++) begin
      int p;
      p = (mLow + 1 + k) % 8;
      if (!mSmm && mIsr[p] && !(mSfnm && p == 2)) return -1;
      if (mIrr[p] && !mImr[p]) return p;
    end
    return -1;
  endfunction

  function automatic int mEoiPick();
    for (int k = 0; k < 8; k++) begin
      int p;
      p = (mLow + 1 + k) % 8;
      if (mIsr[p] && !(mSmm && mImr[p])) return p;
    end
    return -1;
  endfunction

  always @(posedge clk) begin : model
    int win, eo;
    bit [7:0] rise, setB, clrB;
    if (!rstN) begin
      mIrr = 0; mIsr = 0; mImr = 0; mPrev = 0; mLow = 7; mBase = 0; mStep = 0;
      mVec = 0; mSmm = 0; mSfnm = 0; mRdIsr = 0; mUns = 0; mInt = 0;
    end else begin
      win  = mResolve();
      eo   = mEoiPick();
      rise = irqIn & ~mPrev;
      mPrev = irqIn;
      setB = 0; clrB = 0;
      if (intAck && win >= 0) setB[win] = 1'b1;
      if (wrEn && !wrAddr && wrData == 8'h20 && eo >= 0) clrB[eo] = 1'b1;
      mInt = (win >= 0);
      if (intAck) mVec = mBase * 8 + ((win >= 0) ? win : 7);
      mIrr = (mIrr & ~setB) | rise;
      mIsr = (mIsr & ~clrB) | setB;
      if (wrEn && !wrAddr && wrData[4]) begin
        mStep = 1; mSmm = 0; mRdIsr = 0; mUns = wrData[1]; mLow = 7;
      end else if (wrEn && wrAddr) begin
        case (mStep)
          1: begin mBase = wrData / 8; mStep = 2; end
          2: mStep = 3;
          3: begin mSfnm = wrData[4]; mStep = 0; end
          default: mImr = wrData;
        endcase
      end else if (wrEn && !wrAddr && wrData[3]) begin
        if (wrData[6]) mSmm = wrData[5];
        if (wrData[1]) mRdIsr = wrData[0];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R4/R8 intOut vs model", intOut, mInt);
      chk("R5 ackVector vs model", ackVector, mVec[7:0]);
      chk("R7 rdData vs model", rdData, rdAddr ? mImr : (mRdIsr ? mIsr : mIrr));
      chk("R10 unsupported vs model", initUnsupported, mUns);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic initSeq(input logic [7:0] cmd, input logic [7:0] mode);
    wr(1'b0, cmd); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, mode);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 intOut after reset", intOut, 0);
    chk("R1 request readback after reset", rdData, 8'h00);
    chk("R1 vector after reset", ackVector, 8'h00);
    rdAddr = 1'b1; tick(1);
    chk("R1 mask after reset", rdData, 8'h00);
    rdAddr = 1'b0;

    initSeq(8'h11, 8'h01);
    wr(1'b1, 8'h00);
    chk("R10 cascade init not flagged", initUnsupported, 0);

    irqIn = 8'h28; tick(2);
    chk("R2 requests captured", rdData, 8'h28);
    chk("R3 output raised", intOut, 1);
    ack();
    chk("R5 R3 vector picks input 3", ackVector, 8'h43);
    chk("R2 request 3 cleared", rdData, 8'h20);
    tick(2);
    chk("R4 level 5 blocked by in-service 3", intOut, 0);
    wr(1'b0, 8'h0B);
    chk("R7 in-service readback", rdData, 8'h08);
    wr(1'b0, 8'h0A);
    chk("R7 request readback", rdData, 8'h20);

    irqIn = 8'h00; tick(1);
    irqIn = 8'h02; tick(2);
    chk("R4 higher level passes", intOut, 1);
    ack();
    chk("R5 vector input 1", ackVector, 8'h41);
    wr(1'b0, 8'h0B);
    chk("R5 in-service now 1 and 3", rdData, 8'h0A);
    wr(1'b0, 8'h20);
    chk("R6 EOI clears highest", rdData, 8'h08);

    wr(1'b1, 8'h08);
    wr(1'b0, 8'h68);
    tick(2);
    chk("R8 special mask lets level 5 in", intOut, 1);
    ack();
    chk("R8 vector input 5", ackVector, 8'h45);
    chk("R8 in-service 3 and 5", rdData, 8'h28);
    wr(1'b0, 8'h20);
    chk("R9 EOI skips masked 3", rdData, 8'h08);
    wr(1'b0, 8'h20);
    chk("R9 EOI with only masked level", rdData, 8'h08);
    wr(1'b0, 8'h28);
    wr(1'b0, 8'h20);
    chk("R7 mode kept without enable", rdData, 8'h08);
    wr(1'b0, 8'h48);
    wr(1'b0, 8'h20);
    chk("R6 R7 normal EOI after mode off", rdData, 8'h00);

    tick(1);
    ack();
    chk("R5 spurious vector", ackVector, 8'h47);
    chk("R5 spurious leaves in-service", rdData, 8'h00);

    irqIn = 8'h00; tick(1);
    irqIn = 8'h08; tick(2);
    chk("R4 masked request held off", intOut, 0);
    wr(1'b1, 8'h00); tick(2);
    chk("R4 unmasked request raises", intOut, 1);
    ack();
    chk("R5 vector input 3 again", ackVector, 8'h43);
    irqIn = 8'h09; tick(2);
    chk("R12 setup output high", intOut, 1);
    intAck = 1'b1; wrEn = 1'b1; wrAddr = 1'b0; wrData = 8'h20;
    @(negedge clk);
    intAck = 1'b0; wrEn = 1'b0;
    chk("R12 ack and EOI same edge vector", ackVector, 8'h40);
    chk("R12 ack and EOI same edge in-service", rdData, 8'h01);
    wr(1'b0, 8'h20);
    chk("R6 final EOI", rdData, 8'h00);

    initSeq(8'h11, 8'h10);
    chk("R10 init resets read select", rdData, 8'h00);
    irqIn = 8'h00; tick(1);
    irqIn = 8'h04; tick(2);
    ack();
    chk("R11 vector input 2", ackVector, 8'h42);
    irqIn = 8'h44; tick(2);
    chk("R11 cascade level does not block", intOut, 1);
    ack();
    chk("R11 vector input 6", ackVector, 8'h46);

    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h68);
    chk("R7 in-service selected before init", rdData, 8'h44);
    initSeq(8'h13, 8'h00);
    chk("R10 single mode flagged", initUnsupported, 1);
    chk("R10 read select cleared", rdData, 8'h00);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    chk("R10 special mask cleared, EOI clears 2", rdData, 8'h40);
    initSeq(8'h11, 8'h00);
    chk("R10 flag drops on cascade init", initUnsupported, 0);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule